// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timer

This block turns single register accesses into timed bus cycles on an 8-bit raw NAND flash interface. A write to the command register produces a cycle with the command latch enable (CLE) high. A write to the address register produces a cycle with the address latch enable (ALE) high. A write or read of the data register produces a plain data cycle. Every cycle has three phases: a setup phase, then a strobe phase in which the write strobe (WE#) or read strobe (RE#) is low, then a hold phase. The length of each phase comes from one packed 32-bit timing word. Reads and writes take separate values from that word.

Once a cycle finishes, the block holds off sampling of the ready/busy pin for a programmable wait, counted in units of two clocks. Until the wait has passed, the status register reports the device as busy. A configuration bit forces chip enable (CE#) low.

The requester raises `bus_req` and holds it, with the select, direction and write data, until it sees `bus_ack`. Accesses to the configuration, timing and status registers are answered one cycle after they are accepted. Accesses that make a flash cycle are answered once the hold phase ends.

Top module: `nand_cycle_timer`

## Requirements
- R1: After reset the pins are idle: `nand_ce_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_we_n`=1, `nand_re_n`=1 and `nand_dq_oe`=0. `bus_ack` is 0, and the timing word reads back as 0.
- R2: Register select codes are data=0, address=1, command=2, configuration=3, status=4 and timing=5. A command write holds CLE high and ALE low for the whole cycle. An address write does the opposite. A data write keeps both low. During a write strobe `nand_dq_oe`=1 and `nand_dq_out` equals the written byte `bus_wdata[7:0]`.
- R3: For a setup field S, width field W and hold field H, a cycle has S+1 setup clocks, then W+1 clocks with the strobe low, then H+1 hold clocks. `bus_ack` rises on the clock after the last hold clock, so it is high S+W+H+3 clocks after the accepting edge. WE# and RE# are never low together.
- R4: The timing word splits into 4-bit fields. The read half is setup [3:0], hold [7:4], width [11:8] and ready-wait [15:12]. The write half is setup [19:16], hold [23:20], width [27:24] and ready-wait [31:28]. A data read uses the read half and every write uses the write half.
- R5: A data read captures `nand_dq_in` on the clock edge that ends the RE# pulse. That byte is returned zero-extended on `bus_rdata` while `bus_ack` is high. The block never drives the data pins during a read.
- R6: After a flash cycle ends with ready-wait field N, status bit 0 reads 0 (busy) for 2×N clocks, even when the ready/busy pin is high. After that the pin is sampled every clock.
- R7: Status bit 0 follows the ready/busy pin through a two-flop synchronizer, where 1 means the device is ready. The other status bits read 0.
- R8: Configuration bit 5 forces `nand_ce_n` low while it is set. When the bit is clear, `nand_ce_n` is 1.
- R9: The 6-bit configuration register reads back as written. Bit 0 is the device-width bit, where 0 means 8 bits. A write to the status register has no effect.
- R10: `bus_ack` is a one-clock pulse that answers a held request. No new request is accepted while a cycle runs or while `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Request, held until `bus_ack` |
| bus_we | input | 1 | 1 = register write, 0 = register read |
| bus_sel | input | 3 | Register select (0 data, 1 address, 2 command, 3 configuration, 4 status, 5 timing) |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-clock completion pulse |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Data driven to the flash |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_out` |
| nand_dq_in | input | 8 | Data from the flash |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
A register access is answered one clock after its accepting edge. A flash cycle is answered S+W+H+3 clocks after it. With the request raised one clock before acceptance, the bench expects S+W+H+4 request-waiting clocks for a flash cycle and 1 for a register access. It also expects S+2 clocks before the strobe first falls and exactly W+1 clocks of strobe low.

The ready wait is probed by a status read accepted three clocks after the cycle ends. That read must still see busy for a wait of 2 or more and ready for a wait of 0. Pin changes are given at least six clocks to pass the synchronizer.

All counts are taken at the falling clock edge, away from the edge that moves the design.

// File: rtl/nct_pkg.sv
package nct_pkg;

    localparam int FIELD_W  = 4;
    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 32;
    localparam int CFG_W    = 6;
    localparam int CE_BIT   = 5;
    localparam int HALF_W   = WORD_W / 2;

    typedef enum logic [2:0] {
        SEL_DATA   = 3'd0,
        SEL_ADDR   = 3'd1,
        SEL_CMD    = 3'd2,
        SEL_CFG    = 3'd3,
        SEL_STAT   = 3'd4,
        SEL_TIMING = 3'd5
    } sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef enum logic [1:0] {
        KIND_DATA,
        KIND_ADDR,
        KIND_CMD
    } kind_e;

    // One half of the timing word; first member is the most significant nibble.
    typedef struct packed {
        logic [FIELD_W-1:0] ready_wait;
        logic [FIELD_W-1:0] width;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] setup;
    } half_timing_t;

    typedef struct packed {
        logic [FIELD_W-1:0] width;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] setup;
    } phase_times_t;

    typedef struct packed {
        kind_e              kind;
        logic               is_read;
        logic [BYTE_W-1:0]  wbyte;
        phase_times_t       times;
    } cycle_req_t;

    function automatic half_timing_t pick_half(input logic [WORD_W-1:0] word,
                                               input logic is_read);
        return is_read ? half_timing_t'(word[HALF_W-1:0])
                       : half_timing_t'(word[WORD_W-1:HALF_W]);
    endfunction

    function automatic phase_times_t to_phase_times(input half_timing_t h);
        phase_times_t p;
        p.width = h.width;
        p.hold  = h.hold;
        p.setup = h.setup;
        return p;
    endfunction

endpackage

// File: rtl/nct_seq.sv
module nct_seq
    import nct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  cycle_req_t        req,
    input  logic [BYTE_W-1:0] dq_in,
    output phase_e            phase,
    output cycle_req_t        cur,
    output logic              done,
    output logic [BYTE_W-1:0] rbyte
);

    logic [FIELD_W-1:0] cnt;
    logic               last;

    assign last = (cnt == '0);
    assign done = (phase == PH_HOLD) && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            cur   <= '0;
            rbyte <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SETUP;
                        cnt   <= req.times.setup;
                        cur   <= req;
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        phase <= PH_STROBE;
                        cnt   <= cur.times.width;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (last) begin
                        phase <= PH_HOLD;
                        cnt   <= cur.times.hold;
                        if (cur.is_read) begin
                            rbyte <= dq_in;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nct_ready.sv
module nct_ready
    import nct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rb_pin,
    input  logic               cycle_done,
    input  logic [FIELD_W-1:0] wait_n,
    output logic               waiting,
    output logic               ready
);

    localparam int WAIT_W = FIELD_W + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [WAIT_W-1:0]      wait_cnt;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) begin
                    sync_q[i] <= 1'b0;
                end else if (i == 0) begin
                    sync_q[i] <= rb_pin;
                end else begin
                    sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign waiting = (wait_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
            ready    <= 1'b0;
        end else if (cycle_done) begin
            wait_cnt <= {wait_n, 1'b0};
            ready    <= 1'b0;
        end else if (waiting) begin
            wait_cnt <= wait_cnt - 1'b1;
        end else begin
            ready <= sync_q[SYNC_STAGES-1];
        end
    end

endmodule

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer
    import nct_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [2:0]        bus_sel,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [BYTE_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [BYTE_W-1:0] nand_dq_in,
    input  logic              nand_rb
);

    logic [CFG_W-1:0]  cfg_q;
    logic [WORD_W-1:0] timing_q;
    logic              ack_q;
    logic [WORD_W-1:0] rdata_q;

    phase_e            phase;
    cycle_req_t        cur;
    cycle_req_t        new_req;
    logic              seq_done;
    logic [BYTE_W-1:0] rbyte;
    logic              rdy_waiting;
    logic              rdy_flag;

    sel_e              sel;
    logic              accept;
    logic              makes_cycle;
    logic              is_read_cycle;
    half_timing_t      new_half;
    half_timing_t      cur_half;

    assign sel    = sel_e'(bus_sel);
    assign accept = bus_req && !ack_q && (phase == PH_IDLE);

    always_comb begin
        is_read_cycle = (sel == SEL_DATA) && !bus_we;
        makes_cycle   = (sel == SEL_DATA) ||
                        (bus_we && (sel == SEL_ADDR || sel == SEL_CMD));
        new_half      = pick_half(timing_q, is_read_cycle);
        new_req.is_read = is_read_cycle;
        new_req.wbyte   = bus_wdata[BYTE_W-1:0];
        new_req.times   = to_phase_times(new_half);
        unique case (sel)
            SEL_CMD:  new_req.kind = KIND_CMD;
            SEL_ADDR: new_req.kind = KIND_ADDR;
            default:  new_req.kind = KIND_DATA;
        endcase
    end

    nct_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (accept && makes_cycle),
        .req   (new_req),
        .dq_in (nand_dq_in),
        .phase (phase),
        .cur   (cur),
        .done  (seq_done),
        .rbyte (rbyte)
    );

    assign cur_half = pick_half(timing_q, cur.is_read);

    nct_ready #(.SYNC_STAGES(SYNC_STAGES)) u_ready (
        .clk        (clk),
        .rst        (rst),
        .rb_pin     (nand_rb),
        .cycle_done (seq_done),
        .wait_n     (cur_half.ready_wait),
        .waiting    (rdy_waiting),
        .ready      (rdy_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            timing_q <= '0;
            ack_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            ack_q <= 1'b0;
            if (seq_done) begin
                ack_q   <= 1'b1;
                rdata_q <= cur.is_read ? WORD_W'(rbyte) : '0;
            end else if (accept && !makes_cycle) begin
                ack_q   <= 1'b1;
                rdata_q <= '0;
                if (bus_we) begin
                    if (sel == SEL_CFG)    cfg_q    <= bus_wdata[CFG_W-1:0];
                    if (sel == SEL_TIMING) timing_q <= bus_wdata;
                end else begin
                    unique case (sel)
                        SEL_CFG:    rdata_q <= WORD_W'(cfg_q);
                        SEL_STAT:   rdata_q <= WORD_W'(rdy_flag);
                        SEL_TIMING: rdata_q <= timing_q;
                        default:    rdata_q <= '0;
                    endcase
                end
            end
        end
    end

    assign bus_ack     = ack_q;
    assign bus_rdata   = rdata_q;
    assign nand_ce_n   = ~cfg_q[CE_BIT];
    assign nand_cle    = (phase != PH_IDLE) && (cur.kind == KIND_CMD);
    assign nand_ale    = (phase != PH_IDLE) && (cur.kind == KIND_ADDR);
    assign nand_we_n   = !((phase == PH_STROBE) && !cur.is_read);
    assign nand_re_n   = !((phase == PH_STROBE) && cur.is_read);
    assign nand_dq_oe  = (phase != PH_IDLE) && !cur.is_read;
    assign nand_dq_out = cur.wbyte;

endmodule

// File: rtl/nct_checker.sv
module nct_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_req,
    input logic       bus_ack,
    input logic       cle,
    input logic       ale,
    input logic       we_n,
    input logic       re_n,
    input logic [7:0] dq_out,
    input logic       dq_oe,
    input logic       wait_busy,
    input logic       ready
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n)); // R3

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cle, ale})); // R2

    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> dq_oe); // R2

    AST_DQ_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> $stable(dq_out)); // R2

    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !dq_oe); // R5

    AST_WAIT_BUSY: assert property (@(posedge clk) disable iff (rst)
        wait_busy |-> !ready); // R6

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack); // R10

    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(bus_req)); // R10

endmodule

bind nand_cycle_timer nct_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .cle       (nand_cle),
    .ale       (nand_ale),
    .we_n      (nand_we_n),
    .re_n      (nand_re_n),
    .dq_out    (nand_dq_out),
    .dq_oe     (nand_dq_oe),
    .wait_busy (rdy_waiting),
    .ready     (rdy_flag)
);

// File: tb/nand_cycle_timer_test.sv
`timescale 1ns/1ps
module nand_cycle_timer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_sel = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = 8'h00;
    logic        nand_rb = 1'b1;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_cycle_timer uut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    typedef struct {
        logic [31:0] rdata;
        int          lat;
        int          pre;
        int          we_low;
        int          re_low;
        logic        cle;
        logic        ale;
        logic        chk_dq;
        logic [7:0]  dq;
        string       tag;
    } item_t;

    item_t exp_q[$];

    function automatic item_t mk_reg(input logic [31:0] rd, input string tag);
        item_t it;
        it.rdata = rd; it.lat = 1; it.pre = 1; it.we_low = 0; it.re_low = 0;
        it.cle = 0; it.ale = 0; it.chk_dq = 0; it.dq = 0; it.tag = tag;
        return it;
    endfunction

    function automatic item_t mk_wr(input int s, input int w, input int h,
                                    input logic c, input logic a,
                                    input logic [7:0] d, input string tag);
        item_t it;
        it.rdata = 0; it.lat = s + w + h + 4; it.pre = s + 2; it.we_low = w + 1;
        it.re_low = 0; it.cle = c; it.ale = a; it.chk_dq = 1; it.dq = d; it.tag = tag;
        return it;
    endfunction

    function automatic item_t mk_rd(input int s, input int w, input int h,
                                    input logic [7:0] d, input string tag);
        item_t it;
        it.rdata = {24'h0, d}; it.lat = s + w + h + 4; it.pre = s + 2; it.we_low = 0;
        it.re_low = w + 1; it.cle = 0; it.ale = 0; it.chk_dq = 0; it.dq = 0; it.tag = tag;
        return it;
    endfunction

    // Monitor: counts per access at the falling edge, compares on ack.
    int         m_lat = 0, m_pre = 0, m_we = 0, m_re = 0;
    logic       m_seen = 0, m_cle = 0, m_ale = 0;
    logic [7:0] m_dq = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (bus_req && !bus_ack) begin
                m_lat++;
                if (nand_we_n && nand_re_n && !m_seen) m_pre++;
                if (!nand_we_n) begin m_we++; m_seen = 1; m_dq = nand_dq_out; end
                if (!nand_re_n) begin m_re++; m_seen = 1; end
                m_cle = m_cle | nand_cle;
                m_ale = m_ale | nand_ale;
            end else if (bus_ack) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL unexpected ack: actual rdata=%h expected none", bus_rdata);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    if (bus_rdata !== e.rdata || m_lat != e.lat || m_pre != e.pre ||
                        m_we != e.we_low || m_re != e.re_low || m_cle !== e.cle ||
                        m_ale !== e.ale || (e.chk_dq && m_dq !== e.dq)) begin
                        fails++;
                        $display("FAIL %s: actual rdata=%h lat=%0d pre=%0d we=%0d re=%0d cle=%b ale=%b dq=%h expected rdata=%h lat=%0d pre=%0d we=%0d re=%0d cle=%b ale=%b dq=%h",
                            e.tag, bus_rdata, m_lat, m_pre, m_we, m_re, m_cle, m_ale, m_dq,
                            e.rdata, e.lat, e.pre, e.we_low, e.re_low, e.cle, e.ale, e.dq);
                    end
                end
                m_lat = 0; m_pre = 0; m_we = 0; m_re = 0;
                m_seen = 0; m_cle = 0; m_ale = 0;
            end
        end
    end

    // Driver: push the expectation, run the handshake.
    task automatic access(input logic [2:0] sel, input logic we,
                          input logic [31:0] wd, input item_t e);
        exp_q.push_back(e);
        @(posedge clk); #1;
        bus_sel = sel; bus_we = we; bus_wdata = wd; bus_req = 1'b1;
        do @(negedge clk); while (!bus_ack);
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pin_check(input logic act, input logic expv, input string msg);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", msg, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the pins
        pin_check(nand_ce_n, 1'b1, "R1 ce_n");
        pin_check(nand_cle,  1'b0, "R1 cle");
        pin_check(nand_ale,  1'b0, "R1 ale");
        pin_check(nand_we_n, 1'b1, "R1 we_n");
        pin_check(nand_re_n, 1'b1, "R1 re_n");
        pin_check(nand_dq_oe, 1'b0, "R1 dq_oe");
        pin_check(bus_ack,   1'b0, "R1 ack");
        access(3'd5, 1'b0, 0, mk_reg(32'h0, "R1 timing reset"));

        // R4 write half S=2 H=1 W=4, read half S=1 H=2 W=3
        access(3'd5, 1'b1, 32'h0412_0321, mk_reg(32'h0, "R4 timing write"));
        access(3'd5, 1'b0, 0, mk_reg(32'h0412_0321, "R4 timing readback"));
        access(3'd2, 1'b1, 32'h70, mk_wr(2, 4, 1, 1, 0, 8'h70, "R2 R3 command cycle"));
        access(3'd1, 1'b1, 32'h12, mk_wr(2, 4, 1, 0, 1, 8'h12, "R2 R3 address cycle"));
        access(3'd0, 1'b1, 32'hA5, mk_wr(2, 4, 1, 0, 0, 8'hA5, "R2 R4 data write"));
        nand_dq_in = 8'h3C;
        access(3'd0, 1'b0, 0, mk_rd(1, 3, 2, 8'h3C, "R4 R5 data read"));

        // R3 minimum fields
        access(3'd5, 1'b1, 32'h0, mk_reg(32'h0, "R3 timing zero"));
        access(3'd0, 1'b1, 32'h5A, mk_wr(0, 0, 0, 0, 0, 8'h5A, "R3 minimum write"));
        nand_dq_in = 8'hC3;
        access(3'd0, 1'b0, 0, mk_rd(0, 0, 0, 8'hC3, "R3 R5 minimum read"));

        // R3 maximum fields, wait fields 0
        access(3'd5, 1'b1, 32'h0FFF_0FFF, mk_reg(32'h0, "R3 timing max"));
        access(3'd2, 1'b1, 32'hFF, mk_wr(15, 15, 15, 1, 0, 8'hFF, "R3 maximum command"));
        nand_dq_in = 8'h81;
        access(3'd0, 1'b0, 0, mk_rd(15, 15, 15, 8'h81, "R3 maximum read"));

        // R8 chip enable and R9 readback
        access(3'd3, 1'b1, 32'h20, mk_reg(32'h0, "R8 cfg write"));
        @(negedge clk);
        pin_check(nand_ce_n, 1'b0, "R8 ce forced low");
        access(3'd3, 1'b0, 0, mk_reg(32'h20, "R9 cfg readback"));
        access(3'd3, 1'b1, 32'h01, mk_reg(32'h0, "R9 cfg write"));
        @(negedge clk);
        pin_check(nand_ce_n, 1'b1, "R8 ce released");
        access(3'd3, 1'b0, 0, mk_reg(32'h01, "R9 width bit readback"));

        // R6 ready wait after a write (write wait 3 = 6 clocks)
        access(3'd5, 1'b1, 32'h3000_0000, mk_reg(32'h0, "R6 timing"));
        access(3'd0, 1'b1, 32'h11, mk_wr(0, 0, 0, 0, 0, 8'h11, "R6 write cycle"));
        access(3'd4, 1'b0, 0, mk_reg(32'h0, "R6 busy during wait"));
        idle(10);
        access(3'd4, 1'b0, 0, mk_reg(32'h1, "R6 ready after wait"));
        access(3'd5, 1'b1, 32'h0, mk_reg(32'h0, "R6 timing no wait"));
        access(3'd0, 1'b1, 32'h22, mk_wr(0, 0, 0, 0, 0, 8'h22, "R6 write no wait"));
        access(3'd4, 1'b0, 0, mk_reg(32'h1, "R6 ready with zero wait"));
        // read half wait 2 = 4 clocks
        access(3'd5, 1'b1, 32'h0000_2000, mk_reg(32'h0, "R6 read wait timing"));
        nand_dq_in = 8'h44;
        access(3'd0, 1'b0, 0, mk_rd(0, 0, 0, 8'h44, "R6 read cycle"));
        access(3'd4, 1'b0, 0, mk_reg(32'h0, "R6 busy after read wait"));
        idle(8);

        // R7 pin follows, R9 status write ignored
        nand_rb = 1'b0;
        idle(6);
        access(3'd4, 1'b0, 0, mk_reg(32'h0, "R7 pin low"));
        access(3'd4, 1'b1, 32'hFFFF_FFFF, mk_reg(32'h0, "R9 status write"));
        access(3'd4, 1'b0, 0, mk_reg(32'h0, "R9 status write ignored"));
        nand_rb = 1'b1;
        idle(6);
        access(3'd4, 1'b0, 0, mk_reg(32'h1, "R7 pin high"));

        // R10 ack is a single pulse after request drop
        @(negedge clk);
        pin_check(bus_ack, 1'b0, "R10 ack pulse ends");
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 pending: actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule